// File: doc/BRIEF.md
# Video Pixel-Stream Checksum Accumulator

This block computes a 16-bit CRC signature over one colour component of the pixel stream as it enters the display DACs. It takes one pixel per pixel clock at full video rate. Only pixels that the data-enable input marks as active add to the signature. Pixels in the horizontal and vertical blanking intervals have no effect. Because of this, the signature depends only on the order of the active pixels and not on the shape or timing of the sync pulses or the length of the blanking intervals.

Software picks a colour channel and arms the block. The block waits for the next frame start, which is a rising edge on the vertical sync input. It then accumulates exactly one frame. At the following frame start it freezes the signature and raises a done flag. The frozen value can be compared with a value computed offline for a test image, or with a value taken from a device known to be good. A clear command returns the block to its reset state. The horizontal sync signal is not needed, because line boundaries do not enter the signature.

Top module: `vid_crc_sig`

## Requirements
- R1: After reset, `sig_value` is 16'hFFFF, and `sig_done` and `sig_busy` are 0.
- R2: The signature is a CRC with polynomial x^16+x^12+x^5+1 (16'h1021) and seed 16'hFFFF. It has no final inversion. Each active pixel feeds in one 8-bit component, most significant bit first. Over the bytes "123456789" the result is 16'h29B1.
- R3: `chan_sel` selects the component: 0 selects red `pix_rgb[23:16]`, 1 selects green `pix_rgb[15:8]`, and 2 or 3 selects blue `pix_rgb[7:0]`. The block samples the select when it is armed. Later changes to `chan_sel` have no effect on the run in progress.
- R4: A pixel with `pix_de` low never changes the signature.
- R5: An arm pulse loads the seed, clears `sig_done`, sets `sig_busy`, and waits for a rising edge of `vsync`. The frame begins in the cycle where that edge is sampled, and an active pixel in that cycle is included.
- R6: The next rising edge of `vsync` ends the frame. An active pixel in that cycle is not included. `sig_done` rises one cycle after that edge is sampled. The signature and `sig_done` then stay fixed until the next arm or clear.
- R7: Two frames with the same sequence of active pixels give the same signature, whatever their sync pulse widths and blanking lengths.
- R8: A clear pulse loads the seed and sets both `sig_done` and `sig_busy` to 0. When clear and arm arrive in the same cycle, clear wins and the block stays idle.
- R9: While the block is neither armed nor running, pixel and sync activity leaves `sig_value` and `sig_done` unchanged.
- R10: An arm pulse during a run abandons that run. The block reloads the seed and waits for a new frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_rgb | input | 24 | Pixel at the DAC inputs: red [23:16], green [15:8], blue [7:0] |
| pix_de | input | 1 | High for an active (unblanked) pixel |
| vsync | input | 1 | Vertical sync, active high; the rising edge marks a frame start |
| chan_sel | input | 2 | Component select, sampled on arm |
| sig_arm | input | 1 | One-cycle pulse that arms capture of the next frame |
| sig_clear | input | 1 | One-cycle pulse that returns the block to idle with the seed loaded |
| sig_value | output | 16 | Current or frozen signature |
| sig_done | output | 1 | High once a full frame has been captured |
| sig_busy | output | 1 | High while waiting for a frame start or accumulating |

## Verification
Two events can fall on the same cycle: the vertical sync edge that closes a frame, and the arrival of an active pixel. In the same way, the opening edge can coincide with the first pixel of the frame. The bench drives frames in which both sync edges carry an active pixel. The model includes the pixel at the opening edge and drops the pixel at the closing edge, and the frozen signature must match that model. A second collision is arm and clear in the same cycle. The bench judges it by checking that the block stays idle through a whole following frame.

// File: rtl/vid_crc_sig.sv
module vid_crc_sig #(
  parameter int             CH_W  = 8,
  parameter int             CRC_W = 16,
  parameter logic [CRC_W-1:0] POLY = 16'h1021,
  parameter logic [CRC_W-1:0] SEED = 16'hFFFF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [3*CH_W-1:0]  pix_rgb,
  input  logic               pix_de,
  input  logic               vsync,
  input  logic [1:0]         chan_sel,
  input  logic               sig_arm,
  input  logic               sig_clear,
  output logic [CRC_W-1:0]   sig_value,
  output logic               sig_done,
  output logic               sig_busy
);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_RUN} st_t;

  st_t              st;
  logic [CRC_W-1:0] crc;
  logic [1:0]       chan_q;
  logic             vs_q;
  logic [CH_W-1:0]  comp;

  wire vs_rise = vsync & ~vs_q;

  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                input logic [CH_W-1:0]  d);
    logic [CRC_W-1:0] r;
    logic             fb;
    r = c;
    for (int i = CH_W-1; i >= 0; i--) begin
      fb = r[CRC_W-1] ^ d[i];
      r  = {r[CRC_W-2:0], 1'b0};
      if (fb) r = r ^ POLY;
    end
    return r;
  endfunction

  always_comb begin
    case (chan_q)
      2'd0:    comp = pix_rgb[3*CH_W-1:2*CH_W];
      2'd1:    comp = pix_rgb[2*CH_W-1:CH_W];
      default: comp = pix_rgb[CH_W-1:0];
    endcase
  end

  wire [CRC_W-1:0] crc_nxt = crc_step(crc, comp);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      crc    <= SEED;
      sig_done <= 1'b0;
      chan_q <= 2'd0;
      vs_q   <= 1'b0;
    end else begin
      vs_q <= vsync;
      if (sig_clear) begin
        st       <= S_IDLE;
        crc      <= SEED;
        sig_done <= 1'b0;
      end else if (sig_arm) begin
        st       <= S_WAIT;
        crc      <= SEED;
        sig_done <= 1'b0;
        chan_q   <= chan_sel;
      end else begin
        case (st)
          S_WAIT: if (vs_rise) begin
            st <= S_RUN;
            if (pix_de) crc <= crc_nxt;
          end
          S_RUN: if (vs_rise) begin
            st       <= S_IDLE;
            sig_done <= 1'b1;
          end else if (pix_de) begin
            crc <= crc_nxt;
          end
          default: ;
        endcase
      end
    end
  end

  assign sig_value = crc;
  assign sig_busy  = (st != S_IDLE);

  assert_reset_R1: assert property (@(posedge clk)
    !rst_n |=> (sig_value == SEED && !sig_done && !sig_busy));

  assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sig_clear |=> (sig_value == SEED && !sig_done && !sig_busy));

  assert_arm_seed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sig_arm && !sig_clear) |=> (sig_value == SEED && sig_busy && !sig_done));

  assert_blank_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && !pix_de && !sig_arm && !sig_clear) |=> $stable(sig_value));

  assert_done_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sig_done && !sig_arm && !sig_clear) |=> (sig_done && $stable(sig_value)));

  assert_done_needs_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sig_done && !(vsync && !vs_q)) |=> !sig_done);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !sig_arm && !sig_clear) |=> ($stable(sig_value) && $stable(sig_done)));

endmodule

// File: tb/vid_crc_sig_tb.sv
`timescale 1ns/1ps
module vid_crc_sig_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [23:0] pix_rgb;
  logic        pix_de, vsync;
  logic [1:0]  chan_sel;
  logic        sig_arm, sig_clear;
  logic [15:0] sig_value;
  logic        sig_done, sig_busy;

  always #4 clk = ~clk;

  vid_crc_sig u_dut (
    .clk(clk), .rst_n(rst_n), .pix_rgb(pix_rgb), .pix_de(pix_de), .vsync(vsync),
    .chan_sel(chan_sel), .sig_arm(sig_arm), .sig_clear(sig_clear),
    .sig_value(sig_value), .sig_done(sig_done), .sig_busy(sig_busy)
  );

  int          n_chk = 0, n_fail = 0;
  bit          finished = 0;
  logic [15:0] exp_q[$];
  logic        done_d = 1'b0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mdl(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c ^ {b, 8'h00};
    for (int k = 0; k < 8; k++) r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
    return r;
  endfunction

  function automatic logic [7:0] pick(input logic [23:0] px, input int sel);
    if (sel == 0) return px[23:16];
    if (sel == 1) return px[15:8];
    return px[7:0];
  endfunction

  function automatic logic [23:0] pgen(input int f, input int n);
    logic [31:0] h;
    h = (n + 1) * 32'h9E3779B1 ^ (f + 3) * 32'h85EBCA6B;
    return h[28:5];
  endfunction

  task automatic cyc(input bit de, input bit vs, input logic [23:0] px);
    pix_de = de; vsync = vs; pix_rgb = px;
    @(negedge clk);
  endtask

  task automatic arm(input int sel);
    chan_sel = sel[1:0]; sig_arm = 1'b1;
    cyc(0, 0, 24'h0);
    sig_arm = 1'b0;
  endtask

  task automatic frame(input int f, input int lines, input int width, input int hbl,
                       input int vsw, input int vbl, input int sel, input bit edge_px,
                       output logic [15:0] c);
    logic [23:0] px;
    int n = 0;
    c = 16'hFFFF;
    for (int v = 0; v < vsw; v++) begin
      if (v == 0 && edge_px) begin
        px = pgen(f, 999); c = mdl(c, pick(px, sel)); cyc(1, 1, px);
      end else cyc(0, 1, pgen(f + 50, v));
    end
    for (int v = 0; v < vbl; v++) cyc(0, 0, pgen(f + 60, v));
    for (int l = 0; l < lines; l++) begin
      for (int h = 0; h < hbl; h++) cyc(0, 0, pgen(f + 70, h + l));
      for (int w = 0; w < width; w++) begin
        px = pgen(f, n); n++;
        c = mdl(c, pick(px, sel));
        cyc(1, 0, px);
      end
    end
  endtask

  task automatic vs_end(input bit edge_px);
    if (edge_px) cyc(1, 1, pgen(5, 5)); else cyc(0, 1, 24'h0);
    cyc(0, 0, 24'h0);
    cyc(0, 0, 24'h0);
  endtask

  always @(negedge clk) begin
    if (sig_done && !done_d) begin
      if (exp_q.size() == 0) check(0, "R6 done with no frame expected", {16'h0, sig_value}, 32'h0);
      else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        check(sig_value == e, "R2/R6 frame signature", {16'h0, sig_value}, {16'h0, e});
      end
    end
    done_d = sig_done;
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "watchdog expired", 0, 0);
    if (!finished) begin
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] c, ca, last;
    byte msg[9] = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
    rst_n = 1'b0; pix_rgb = 24'h0; pix_de = 1'b0; vsync = 1'b0;
    chan_sel = 2'd0; sig_arm = 1'b0; sig_clear = 1'b0;
    repeat (3) @(negedge clk);
    check(sig_value == 16'hFFFF && !sig_done && !sig_busy, "R1 reset state",
          {13'h0, sig_busy, sig_done, 1'b0, sig_value}, 32'hFFFF);
    rst_n = 1'b1;
    cyc(0, 0, 24'h0);

    // R2: check value over ASCII digits, with blanked noise in between (R4)
    arm(0);
    cyc(0, 1, 24'h0); cyc(0, 0, 24'h0);
    foreach (msg[i]) begin
      cyc(1, 0, {msg[i], 8'h55, 8'hAA});
      cyc(0, 0, {8'hEE, 8'h11, 8'h22});
    end
    exp_q.push_back(16'h29B1);
    vs_end(0);
    check(sig_value == 16'h29B1 && sig_done, "R2 check value", {16'h0, sig_value}, 32'h29B1);

    // R7: same active pixels, two different sync and blanking timings
    arm(1);
    frame(1, 3, 6, 4, 2, 3, 1, 0, c); ca = c; exp_q.push_back(c);
    vs_end(0);
    arm(1);
    frame(1, 3, 6, 9, 5, 1, 1, 0, c); exp_q.push_back(c);
    vs_end(0);
    check(sig_value == ca, "R7 timing independence", {16'h0, sig_value}, {16'h0, ca});

    // R3: selects 2 and 3 both pick blue
    arm(2);
    frame(2, 2, 5, 3, 1, 2, 2, 0, c); ca = c; exp_q.push_back(c);
    vs_end(0);
    arm(3);
    frame(2, 2, 5, 3, 1, 2, 2, 0, c); exp_q.push_back(c);
    vs_end(0);
    check(sig_value == ca, "R3 select 3 is blue", {16'h0, sig_value}, {16'h0, ca});

    // R3: select change after arm is ignored
    arm(0);
    chan_sel = 2'd2;
    frame(3, 2, 7, 2, 1, 1, 0, 0, c); exp_q.push_back(c);
    vs_end(0);
    check(sig_value == c, "R3 select latched on arm", {16'h0, sig_value}, {16'h0, c});

    // R5/R6: active pixel on both opening and closing edges
    arm(1);
    frame(4, 2, 4, 2, 2, 1, 1, 1, c); exp_q.push_back(c);
    vs_end(1);
    check(sig_value == c, "R5/R6 edge pixels", {16'h0, sig_value}, {16'h0, c});
    last = c;

    // R6/R9: after done, further frames change nothing
    frame(9, 2, 4, 2, 1, 1, 0, 0, c);
    vs_end(1);
    check(sig_value == last && sig_done, "R6 frozen after done", {15'h0, sig_done, sig_value}, {16'h1, last});

    // R8: clear
    sig_clear = 1'b1; cyc(0, 0, 24'h0); sig_clear = 1'b0;
    check(sig_value == 16'hFFFF && !sig_done && !sig_busy, "R8 clear", {14'h0, sig_busy, sig_done, sig_value}, 32'hFFFF);
    // R8: clear and arm together stay idle; R9 idle activity ignored
    sig_clear = 1'b1; sig_arm = 1'b1; cyc(0, 0, 24'h0); sig_clear = 1'b0; sig_arm = 1'b0;
    check(!sig_busy, "R8 clear beats arm", {31'h0, sig_busy}, 32'h0);
    frame(10, 2, 4, 1, 1, 1, 0, 1, c);
    vs_end(1);
    check(sig_value == 16'hFFFF && !sig_done, "R9 idle ignores frames", {15'h0, sig_done, sig_value}, 32'hFFFF);

    // R10: re-arm mid-run restarts
    arm(0);
    frame(11, 2, 5, 1, 1, 1, 0, 0, c);
    check(sig_busy && !sig_done, "R10 running before re-arm", {30'h0, sig_busy, sig_done}, 32'h2);
    arm(0);
    check(sig_value == 16'hFFFF, "R10 re-arm reloads seed", {16'h0, sig_value}, 32'hFFFF);
    frame(12, 2, 5, 3, 2, 1, 0, 0, c); exp_q.push_back(c);
    vs_end(0);
    check(sig_value == c, "R10 restarted frame", {16'h0, sig_value}, {16'h0, c});

    repeat (4) cyc(0, 0, 24'h0);
    check(exp_q.size() == 0, "R6 every armed frame completed", exp_q.size(), 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule